// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Slice

This block is one arithmetic slice for datapath arrays. It takes a lane-0 operand pair and a lane-1 operand pair, multiplies each pair, and then does one of four things, picked by a static mode parameter. In plain multiply mode it passes the lane-0 product straight out. In accumulate mode it adds that product to a running total, or subtracts it. In pair mode it adds or subtracts the two products. In pair-accumulate mode it takes that pair result and adds it to the running total, or subtracts it.

Several control inputs are sampled on every cycle. One picks signed or unsigned operands. One picks add or subtract when the two products are combined. One picks add or subtract in the accumulator. One makes the accumulator load a new value. One picks where the lane-0 operands come from: the input ports, or the chain inputs fed by the operand registers of the previous slice.

Each control bit travels down the pipeline with the operands it was sampled with. The input, product and output stages can each be turned on or off by a parameter, so the latency is 0 to 3 cycles. A valid flag runs through the same stages as the data. The operand width W is one of 9, 18 or 36, and a single W applies to the whole slice.

The accumulate step uses one of four operations, decoded in the combine stage:
- HOLD: no valid data is present.
- LOAD: valid data with the load bit set.
- SUB: valid data with the accumulator subtract bit set.
- ADD: any other valid data.

All four operations can follow one another in any order. Reset forces the slice back to a cleared accumulator.

Top module: `mac_slice`

## Requirements
- R1: In plain multiply mode (MODE_MULT), the result is the product P0 of the two selected lane-0 operands, sign-extended to RW bits. The lane-1 operands, comb_sub, acc_sub and acc_load have no effect.
- R2: When sgn=1 in a cycle, the operands of both lanes sampled in that cycle are W-bit two's-complement numbers. When sgn=0, they are unsigned numbers.
- R3: In pair mode (MODE_ADDSUB), the result is P0+P1 when comb_sub=0 and P0-P1 when comb_sub=1, modulo 2^RW. P1 is the product of the lane-1 operands.
- R4: In accumulate mode (MODE_MAC), each valid input changes the accumulator to acc+P0 when acc_sub=0, or to acc-P0 when acc_sub=1. The result shows the updated accumulator.
- R5: In pair-accumulate mode (MODE_ADDSUBSUM), each valid input changes the accumulator by the pair value (P0+P1 or P0-P1, chosen by comb_sub). The accumulator adds that value when acc_sub=0 and subtracts it when acc_sub=1.
- R6: In the accumulating modes, a valid input with acc_load=1 replaces the accumulator with the incoming value (P0, or the pair value). acc_sub is then ignored.
- R7: When shift_sel=1, the lane-0 operands are taken from a_chain_in and b_chain_in. When shift_sel=0, they are taken from a0 and b0.
- R8: a_chain_out and b_chain_out show the selected lane-0 operands. They appear one cycle later when IN_REG=1, and in the same cycle when IN_REG=0. They are loaded on every cycle, whether or not the input is valid.
- R9: The latency is IN_REG+PIPE_REG+OUT_REG cycles. out_valid follows in_valid with exactly that latency. Every control bit acts on the operands it was sampled with.
- R10: The synchronous active-high reset clears every stage: out_valid=0, result=0 and accumulator=0.
- R11: RW = 2W+GUARD, with GUARD of at least 2 (default 16). Accumulator and pair arithmetic wrap silently modulo 2^RW.
- R12: In the accumulating modes, a cycle with no valid data at the combine stage leaves the accumulator unchanged. With no valid data, result holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls in this cycle are valid |
| sgn | input | 1 | 1 = signed operands, 0 = unsigned, this cycle |
| shift_sel | input | 1 | 1 = lane-0 operands from the chain inputs |
| comb_sub | input | 1 | 1 = subtract the lane-1 product from the lane-0 product |
| acc_sub | input | 1 | 1 = accumulator subtracts |
| acc_load | input | 1 | 1 = accumulator loads the incoming value |
| a0 | input | W | Lane-0 operand A |
| b0 | input | W | Lane-0 operand B |
| a1 | input | W | Lane-1 operand A |
| b1 | input | W | Lane-1 operand B |
| a_chain_in | input | W | A operand from the previous slice |
| b_chain_in | input | W | B operand from the previous slice |
| a_chain_out | output | W | Lane-0 A operand held by the input stage |
| b_chain_out | output | W | Lane-0 B operand held by the input stage |
| out_valid | output | 1 | result carries valid data |
| result | output | 2W+GUARD | Product, pair value or accumulator |

## Verification
The latency assertion assumes that in_valid is low whenever reset is high. The operand-source and accumulator assertions assume that reset is not asserted part-way through a stage transfer. The bench holds all inputs, including in_valid, at zero during reset and never pulses reset again. It then sweeps every lane-0 A value against 64 spread B values, including 0, 255, 256 and 511. The control bits vary from cycle to cycle according to fixed patterns, with regular valid gaps, so that all four accumulator operations and both operand sources meet every configuration. One instance uses a small GUARD so that its accumulator wraps many times.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

    typedef enum logic [1:0] {
        MODE_MULT      = 2'd0,
        MODE_MAC       = 2'd1,
        MODE_ADDSUB    = 2'd2,
        MODE_ADDSUBSUM = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_LOAD = 2'd3
    } acc_op_e;

    typedef struct packed {
        logic valid;
        logic sgn;
        logic comb_sub;
        logic acc_sub;
        logic acc_load;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic bit mode_has_pair(mode_e m);
        return (m == MODE_ADDSUB) || (m == MODE_ADDSUBSUM);
    endfunction

    function automatic bit mode_has_acc(mode_e m);
        return (m == MODE_MAC) || (m == MODE_ADDSUBSUM);
    endfunction

endpackage

// File: rtl/mac_opt_reg.sv
`timescale 1ns/1ps
module mac_opt_reg #(
    parameter int WIDTH = 8,
    parameter bit EN    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (EN) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_bypass
            logic unused_clkrst;
            assign unused_clkrst = clk ^ rst;
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mac_operand_stage.sv
`timescale 1ns/1ps
module mac_operand_stage
    import mac_pkg::*;
#(
    parameter int W      = 9,
    parameter bit IN_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_sel,
    input  logic [W-1:0] a0,
    input  logic [W-1:0] b0,
    input  logic [W-1:0] a1,
    input  logic [W-1:0] b1,
    input  logic [W-1:0] a_chain_in,
    input  logic [W-1:0] b_chain_in,
    input  ctrl_t        ctrl_d,
    output logic [W-1:0] a0_q,
    output logic [W-1:0] b0_q,
    output logic [W-1:0] a1_q,
    output logic [W-1:0] b1_q,
    output ctrl_t        ctrl_q
);

    localparam int PACK_W = 4 * W + CTRL_W;

    logic [W-1:0]      a0_sel;
    logic [W-1:0]      b0_sel;
    logic [PACK_W-1:0] pack_d;
    logic [PACK_W-1:0] pack_q;

    // Operand source: parallel ports or the neighbour's operand registers
    always_comb begin
        if (shift_sel) begin
            a0_sel = a_chain_in;
            b0_sel = b_chain_in;
        end else begin
            a0_sel = a0;
            b0_sel = b0;
        end
    end

    assign pack_d = {a0_sel, b0_sel, a1, b1, ctrl_d};

    mac_opt_reg #(.WIDTH(PACK_W), .EN(IN_REG)) u_in_reg (
        .clk (clk),
        .rst (rst),
        .d   (pack_d),
        .q   (pack_q)
    );

    assign {a0_q, b0_q, a1_q, b1_q, ctrl_q} = pack_q;

    generate
        if (IN_REG) begin : g_chk
            p_shift_load_r7: assert property (@(posedge clk) disable iff (rst)
                shift_sel |=> (a0_q == $past(a_chain_in)) && (b0_q == $past(b_chain_in)));
            p_direct_load_r7: assert property (@(posedge clk) disable iff (rst)
                !shift_sel |=> (a0_q == $past(a0)) && (b0_q == $past(b0)));
            p_ctrl_follows_r9: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ctrl_q == $past(ctrl_d));
        end
    endgenerate

endmodule

// File: rtl/mac_product_stage.sv
`timescale 1ns/1ps
module mac_product_stage
    import mac_pkg::*;
#(
    parameter mode_e MODE     = MODE_MAC,
    parameter int    W        = 9,
    parameter int    RW       = 34,
    parameter bit    PIPE_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a0,
    input  logic [W-1:0]  b0,
    input  logic [W-1:0]  a1,
    input  logic [W-1:0]  b1,
    input  ctrl_t         ctrl_d,
    output logic [RW-1:0] p0_q,
    output logic [RW-1:0] p1_q,
    output ctrl_t         ctrl_q
);

    localparam int XW     = W + 1;
    localparam int MW     = 2 * XW;
    localparam int PACK_W = 2 * RW + CTRL_W;

    // Operands widened by one bit so one signed multiplier serves both kinds
    function automatic logic signed [MW-1:0] widen_mul(
        input logic [W-1:0] x,
        input logic [W-1:0] y,
        input logic         is_signed
    );
        logic signed [MW-1:0] xe;
        logic signed [MW-1:0] ye;
        xe = $signed({is_signed & x[W-1], x});
        ye = $signed({is_signed & y[W-1], y});
        return xe * ye;
    endfunction

    logic signed [MW-1:0] raw0;
    logic signed [RW-1:0] ext0;
    logic signed [RW-1:0] ext1;
    logic [PACK_W-1:0]    pack_d;
    logic [PACK_W-1:0]    pack_q;

    assign raw0 = widen_mul(a0, b0, ctrl_d.sgn);
    assign ext0 = raw0;

    generate
        if (mode_has_pair(MODE)) begin : g_pair
            logic signed [MW-1:0] raw1;
            assign raw1 = widen_mul(a1, b1, ctrl_d.sgn);
            assign ext1 = raw1;
        end else begin : g_single
            logic unused_lane1;
            assign unused_lane1 = ^{a1, b1};
            assign ext1 = '0;
        end
    endgenerate

    assign pack_d = {ext0, ext1, ctrl_d};

    mac_opt_reg #(.WIDTH(PACK_W), .EN(PIPE_REG)) u_pipe_reg (
        .clk (clk),
        .rst (rst),
        .d   (pack_d),
        .q   (pack_q)
    );

    assign {p0_q, p1_q, ctrl_q} = pack_q;

    p_unsigned_nonneg_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_d.sgn |-> !ext0[RW-1]);

    p_signed_neg_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_d.sgn && (a0 != '0) && (b0 != '0) && (a0[W-1] != b0[W-1])) |-> ext0[RW-1]);

endmodule

// File: rtl/mac_combine_stage.sv
`timescale 1ns/1ps
module mac_combine_stage
    import mac_pkg::*;
#(
    parameter mode_e MODE    = MODE_MAC,
    parameter int    RW      = 34,
    parameter bit    OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] p0,
    input  logic [RW-1:0] p1,
    input  ctrl_t         ctrl_d,
    output logic [RW-1:0] result,
    output logic          out_valid
);

    logic [RW-1:0] val;
    logic [RW-1:0] result_d;
    logic [RW:0]   out_d;
    logic [RW:0]   out_q;
    acc_op_e       op;

    generate
        if (mode_has_pair(MODE)) begin : g_pair
            assign val = ctrl_d.comb_sub ? (p0 - p1) : (p0 + p1);
        end else begin : g_single
            logic unused_pair;
            assign unused_pair = ^{p1, ctrl_d.comb_sub};
            assign val = p0;
        end
    endgenerate

    // Accumulator operation decode: load wins over subtract
    always_comb begin
        if (!ctrl_d.valid)        op = OP_HOLD;
        else if (ctrl_d.acc_load) op = OP_LOAD;
        else if (ctrl_d.acc_sub)  op = OP_SUB;
        else                      op = OP_ADD;
    end

    generate
        if (mode_has_acc(MODE)) begin : g_acc
            logic [RW-1:0] acc_q;
            logic [RW-1:0] acc_next;

            always_comb begin
                unique case (op)
                    OP_HOLD: acc_next = acc_q;
                    OP_ADD:  acc_next = acc_q + val;
                    OP_SUB:  acc_next = acc_q - val;
                    OP_LOAD: acc_next = val;
                    default: acc_next = acc_q;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) acc_q <= '0;
                else     acc_q <= acc_next;
            end

            assign result_d = acc_next;

            p_acc_hold_r12: assert property (@(posedge clk) disable iff (rst)
                (op == OP_HOLD) |=> acc_q == $past(acc_q));
            p_acc_load_r6: assert property (@(posedge clk) disable iff (rst)
                (op == OP_LOAD) |=> acc_q == $past(val));
            p_acc_add_r4: assert property (@(posedge clk) disable iff (rst)
                (op == OP_ADD) |=> acc_q == RW'($past(acc_q) + $past(val)));
            p_acc_sub_r5: assert property (@(posedge clk) disable iff (rst)
                (op == OP_SUB) |=> acc_q == RW'($past(acc_q) - $past(val)));
        end else begin : g_noacc
            logic unused_acc;
            assign unused_acc = ^{op, ctrl_d.acc_sub, ctrl_d.acc_load};
            assign result_d = val;
        end
    endgenerate

    logic unused_sgn;
    assign unused_sgn = ctrl_d.sgn;

    assign out_d = {ctrl_d.valid, result_d};

    mac_opt_reg #(.WIDTH(RW + 1), .EN(OUT_REG)) u_out_reg (
        .clk (clk),
        .rst (rst),
        .d   (out_d),
        .q   (out_q)
    );

    assign {out_valid, result} = out_q;

endmodule

// File: rtl/mac_slice.sv
`timescale 1ns/1ps
module mac_slice
    import mac_pkg::*;
#(
    parameter mode_e MODE     = MODE_MAC,
    parameter int    W        = 9,
    parameter int    GUARD    = 16,
    parameter bit    IN_REG   = 1'b1,
    parameter bit    PIPE_REG = 1'b1,
    parameter bit    OUT_REG  = 1'b1,
    localparam int   RW       = 2 * W + GUARD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          sgn,
    input  logic          shift_sel,
    input  logic          comb_sub,
    input  logic          acc_sub,
    input  logic          acc_load,
    input  logic [W-1:0]  a0,
    input  logic [W-1:0]  b0,
    input  logic [W-1:0]  a1,
    input  logic [W-1:0]  b1,
    input  logic [W-1:0]  a_chain_in,
    input  logic [W-1:0]  b_chain_in,
    output logic [W-1:0]  a_chain_out,
    output logic [W-1:0]  b_chain_out,
    output logic          out_valid,
    output logic [RW-1:0] result
);

    localparam int LAT = int'(IN_REG) + int'(PIPE_REG) + int'(OUT_REG);

    ctrl_t         ctrl_in;
    ctrl_t         ctrl_s1;
    ctrl_t         ctrl_s2;
    logic [W-1:0]  a0_s1;
    logic [W-1:0]  b0_s1;
    logic [W-1:0]  a1_s1;
    logic [W-1:0]  b1_s1;
    logic [RW-1:0] p0_s2;
    logic [RW-1:0] p1_s2;

    assign ctrl_in = '{valid: in_valid, sgn: sgn, comb_sub: comb_sub,
                       acc_sub: acc_sub, acc_load: acc_load};

    mac_operand_stage #(.W(W), .IN_REG(IN_REG)) u_operands (
        .clk        (clk),
        .rst        (rst),
        .shift_sel  (shift_sel),
        .a0         (a0),
        .b0         (b0),
        .a1         (a1),
        .b1         (b1),
        .a_chain_in (a_chain_in),
        .b_chain_in (b_chain_in),
        .ctrl_d     (ctrl_in),
        .a0_q       (a0_s1),
        .b0_q       (b0_s1),
        .a1_q       (a1_s1),
        .b1_q       (b1_s1),
        .ctrl_q     (ctrl_s1)
    );

    assign a_chain_out = a0_s1;
    assign b_chain_out = b0_s1;

    mac_product_stage #(.MODE(MODE), .W(W), .RW(RW), .PIPE_REG(PIPE_REG)) u_products (
        .clk    (clk),
        .rst    (rst),
        .a0     (a0_s1),
        .b0     (b0_s1),
        .a1     (a1_s1),
        .b1     (b1_s1),
        .ctrl_d (ctrl_s1),
        .p0_q   (p0_s2),
        .p1_q   (p1_s2),
        .ctrl_q (ctrl_s2)
    );

    mac_combine_stage #(.MODE(MODE), .RW(RW), .OUT_REG(OUT_REG)) u_combine (
        .clk       (clk),
        .rst       (rst),
        .p0        (p0_s2),
        .p1        (p1_s2),
        .ctrl_d    (ctrl_s2),
        .result    (result),
        .out_valid (out_valid)
    );

    generate
        if (LAT > 0) begin : g_lat_chk
            logic [1:0] since_rst;
            always_ff @(posedge clk) begin
                if (rst)                  since_rst <= 2'd0;
                else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            end
            p_valid_latency_r9: assert property (@(posedge clk) disable iff (rst)
                (int'(since_rst) >= LAT) |-> out_valid == $past(in_valid, LAT));
        end else begin : g_comb_chk
            p_valid_comb_r9: assert property (@(posedge clk) disable iff (rst)
                1'b1 |-> out_valid == in_valid);
        end
    endgenerate

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (OUT_REG == 1'b0) || (!out_valid && (result == '0)));

endmodule

// File: tb/sim_mac_slice.sv
`timescale 1ns/1ps
module sim_mac_slice;
    import mac_pkg::*;

    localparam int W   = 9;
    localparam int RWA = 2 * W + 16;
    localparam int RWB = 2 * W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, sgn = 1'b0, shift_sel = 1'b0;
    logic comb_sub = 1'b0, acc_sub = 1'b0, acc_load = 1'b0;
    logic [W-1:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0, ach = '0, bch = '0;

    logic [W-1:0]   ac0, bc0, ac1, bc1, ac2, bc2, ac3, bc3;
    logic           ov0, ov1, ov2, ov3;
    logic [RWA-1:0] res0, res1, res2;
    logic [RWB-1:0] res3;

    always #4 clk = ~clk;

    mac_slice #(.MODE(MODE_MULT), .W(W), .GUARD(16), .IN_REG(1'b1), .PIPE_REG(1'b1), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sgn(sgn), .shift_sel(shift_sel),
        .comb_sub(comb_sub), .acc_sub(acc_sub), .acc_load(acc_load),
        .a0(a0), .b0(b0), .a1(a1), .b1(b1), .a_chain_in(ach), .b_chain_in(bch),
        .a_chain_out(ac0), .b_chain_out(bc0), .out_valid(ov0), .result(res0));

    mac_slice #(.MODE(MODE_ADDSUB), .W(W), .GUARD(16), .IN_REG(1'b0), .PIPE_REG(1'b1), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sgn(sgn), .shift_sel(shift_sel),
        .comb_sub(comb_sub), .acc_sub(acc_sub), .acc_load(acc_load),
        .a0(a0), .b0(b0), .a1(a1), .b1(b1), .a_chain_in(ach), .b_chain_in(bch),
        .a_chain_out(ac1), .b_chain_out(bc1), .out_valid(ov1), .result(res1));

    mac_slice #(.MODE(MODE_MAC), .W(W), .GUARD(16), .IN_REG(1'b1), .PIPE_REG(1'b0), .OUT_REG(1'b1)) u2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sgn(sgn), .shift_sel(shift_sel),
        .comb_sub(comb_sub), .acc_sub(acc_sub), .acc_load(acc_load),
        .a0(a0), .b0(b0), .a1(a1), .b1(b1), .a_chain_in(ach), .b_chain_in(bch),
        .a_chain_out(ac2), .b_chain_out(bc2), .out_valid(ov2), .result(res2));

    mac_slice #(.MODE(MODE_ADDSUBSUM), .W(W), .GUARD(2), .IN_REG(1'b0), .PIPE_REG(1'b0), .OUT_REG(1'b0)) u3 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sgn(sgn), .shift_sel(shift_sel),
        .comb_sub(comb_sub), .acc_sub(acc_sub), .acc_load(acc_load),
        .a0(a0), .b0(b0), .a1(a1), .b1(b1), .a_chain_in(ach), .b_chain_in(bch),
        .a_chain_out(ac3), .b_chain_out(bc3), .out_valid(ov3), .result(res3));

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    longint expq [4][64];
    int     cycq [4][64];
    int     wp [4];
    int     rp [4];
    longint last_exp [4];
    longint acc2 = 0, acc3 = 0;
    int     prev_a = 0, prev_b = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic longint ext(input int v, input bit s);
        if (s && v[W-1]) return longint'(v) - (longint'(1) << W);
        return longint'(v);
    endfunction

    function automatic longint mask(input longint x, input int rw);
        return x & ((longint'(1) << rw) - 1);
    endfunction

    task automatic push(input int u, input longint v);
        expq[u][wp[u] % 64] = v;
        cycq[u][wp[u] % 64] = cyc;
        wp[u]++;
    endtask

    task automatic observe(input int u, input logic ov, input longint res, input int lat,
                           input string tag, input bit stateful);
        if (ov) begin
            if (rp[u] == wp[u]) begin
                check(1'b0, "R9 spurious valid", 1, 0);
            end else begin
                check(res == expq[u][rp[u] % 64], tag, res, expq[u][rp[u] % 64]);
                check(cyc - cycq[u][rp[u] % 64] == lat, "R9 latency", cyc - cycq[u][rp[u] % 64], lat);
                last_exp[u] = expq[u][rp[u] % 64];
                rp[u]++;
            end
        end else if (stateful) begin
            check(res == last_exp[u], "R12 hold", res, last_exp[u]);
        end
    endtask

    // Drive one input cycle and update the arithmetic reference
    task automatic drive(input int i, input bit valid_en);
        int  av, bv, a1v, b1v, acv, bcv, ae, be;
        bit  s, sh, cs, as, ld, vl;
        longint p0, p1, pv;
        av  = i & 511;
        bv  = (((i >> 9) << 3) | ((i >> 9) & 7)) & 511;
        a1v = (i * 29 + 11) & 511;
        b1v = (i * 53 + 7) & 511;
        acv = (i * 71 + 3) & 511;
        bcv = (~av) & 511;
        s   = ((i >> 1) & 1) ^ ((i >> 9) & 1);
        sh  = (i % 5) == 2;
        cs  = (i >> 2) & 1;
        as  = ((i >> 3) & 1) ^ (i & 1);
        ld  = (i % 113) == 0;
        vl  = valid_en && ((i % 11) != 4);
        a0 = W'(av); b0 = W'(bv); a1 = W'(a1v); b1 = W'(b1v);
        ach = W'(acv); bch = W'(bcv);
        sgn = s; shift_sel = sh; comb_sub = cs; acc_sub = as; acc_load = ld; in_valid = vl;
        ae = sh ? acv : av;
        be = sh ? bcv : bv;
        if (vl) begin
            p0 = ext(ae, s) * ext(be, s);
            p1 = ext(a1v, s) * ext(b1v, s);
            pv = cs ? p0 - p1 : p0 + p1;
            push(0, mask(p0, RWA));
            push(1, mask(pv, RWA));
            acc2 = ld ? p0 : (as ? acc2 - p0 : acc2 + p0);
            acc2 = mask(acc2, RWA);
            push(2, acc2);
            acc3 = ld ? pv : (as ? acc3 - pv : acc3 + pv);
            acc3 = mask(acc3, RWB);
            push(3, acc3);
        end
        #1;
        // R7 R8: chain outputs show the selected operands
        check(ac1 == W'(ae) && bc1 == W'(be), "R7 chain comb", longint'({ac1, bc1}), longint'({W'(ae), W'(be)}));
        if (cyc > 0)
            check(ac0 == W'(prev_a) && bc0 == W'(prev_b), "R8 chain reg", longint'({ac0, bc0}), longint'({W'(prev_a), W'(prev_b)}));
        prev_a = ae;
        prev_b = be;
        observe(0, ov0, longint'(res0), 3, "R1 R2 R7 mult", 1'b0);
        observe(1, ov1, longint'(res1), 1, "R3 R2 pair", 1'b0);
        observe(2, ov2, longint'(res2), 2, "R4 R6 mac", 1'b1);
        observe(3, ov3, longint'(res3), 0, "R5 R6 R11 pair-acc wrap", 1'b1);
    endtask

    initial begin
        for (int u = 0; u < 4; u++) begin
            wp[u] = 0; rp[u] = 0; last_exp[u] = 0;
        end
        repeat (4) @(negedge clk);
        #1;
        // R10: reset state
        check(!ov0 && !ov1 && !ov2 && !ov3, "R10 valid", longint'({ov0, ov1, ov2, ov3}), 0);
        check(res0 == '0, "R10 result u0", longint'(res0), 0);
        check(res1 == '0, "R10 result u1", longint'(res1), 0);
        check(res2 == '0, "R10 result u2", longint'(res2), 0);
        check(res3 == '0, "R10 result u3", longint'(res3), 0);
        check(ac0 == '0 && bc0 == '0, "R10 chain", longint'({ac0, bc0}), 0);
        for (int i = 0; i < 512 * 64; i++) begin
            @(negedge clk);
            rst = 1'b0;
            drive(i, 1'b1);
            cyc++;
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            drive(k, 1'b0);
            cyc++;
        end
        check(rp[0] == wp[0] && rp[1] == wp[1] && rp[2] == wp[2] && rp[3] == wp[3],
              "R9 drain", longint'(rp[2]), longint'(wp[2]));
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(64'd200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 512 * 64 + 6);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule